// File: doc/BRIEF.md
# Dual-Clock SECDED FIFO

This block is a first-in first-out buffer between two unrelated clock domains. It carries 64-bit words. On each accepted write it computes 8 check bits of an extended Hamming code. The data word and the check bits are stored together as one 72-bit entry. On each accepted read the stored entry is decoded. Any single flipped bit is repaired on the way to the output only; the entry held in storage stays as it was written. The decoder reports a single-error outcome and a double-error outcome on two separate flags.

Each side sees its own view of the occupancy: full and almost-full in the write domain, empty and almost-empty in the read domain. Both pointers appear as count outputs. A write into a full buffer raises a one-cycle overflow strobe, and a read from an empty buffer raises a one-cycle underflow strobe. An injection mask on the write side lets a bench corrupt stored entries on purpose. One active-high reset clears the pointers and flags of both domains at once, without waiting for a clock.

Top module: `secded_async_fifo`

## Requirements
- R1: While and after reset (held at least three cycles of each clock), empty=1, almost_empty=1, full=0, almost_full=0, and wr_count=rd_count=0.
- R2: Words are read out in write order. rd_data, rd_check, err_single and err_double change on the first rd_clk edge after the edge that accepted the read. For an uncorrupted entry, both error flags are 0 and rd_data equals the written word.
- R3: One wr_clk edge after an accepted write, wr_check shows that word's check bits. The bit layout is as follows. Data bit j is placed at the j-th integer from 3 upward that is not a power of two. Check bit i (i=0..6) is the XOR of the data bits whose position has bit i set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R4: Setting one bit of wr_inject in range 63:0 flips that data bit in the stored entry. On read, rd_data is corrected, err_single=1 and err_double=0.
- R5: A single flip in a stored check bit (wr_inject bits 71:64, where bit 71 is the overall parity) gives rd_data equal to the written word, err_single=1 and err_double=0.
- R6: Two flipped bits in one entry give err_double=1 and err_single=0.
- R7: Correction is not written back. rd_check shows the stored check bits, including any injected flip (expected value: written check XOR wr_inject[71:64]).
- R8: A write with full=1 is ignored: wr_count does not change, and no extra word appears on later reads. It also makes wr_overflow high for exactly one wr_clk cycle.
- R9: A read with empty=1 is ignored: rd_count, rd_data and the error flags do not change. It also makes rd_underflow high for exactly one rd_clk cycle.
- R10: almost_full=1 exactly when the write-side fill is at least ALMOST_FULL_LVL (default DEPTH-4). full=1 exactly when that fill equals DEPTH.
- R11: almost_empty=1 exactly when the read-side fill is at most ALMOST_EMPTY_LVL (default 4). empty=1 exactly when that fill is 0.
- R12: Reset does not change rd_data, rd_check, err_single, err_double or wr_check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst | input | 1 | Asynchronous active-high reset of pointers and flags |
| wr_en | input | 1 | Write request |
| wr_data | input | 64 | Word to store |
| wr_inject | input | 72 | XOR mask applied to the stored entry (test hook) |
| rd_en | input | 1 | Read request |
| rd_data | output | 64 | Corrected output word |
| rd_check | output | 8 | Stored check bits of the last read entry |
| err_single | output | 1 | Single error seen and corrected |
| err_double | output | 1 | Double error seen, not correctable |
| wr_check | output | 8 | Check bits of the last accepted write |
| full | output | 1 | Write side: no room |
| almost_full | output | 1 | Write side: fill at or above threshold |
| empty | output | 1 | Read side: nothing stored |
| almost_empty | output | 1 | Read side: fill at or below threshold |
| wr_count | output | AW+1 | Binary write pointer |
| rd_count | output | AW+1 | Binary read pointer |
| wr_overflow | output | 1 | One-cycle strobe for a write refused while full |
| rd_underflow | output | 1 | One-cycle strobe for a read refused while empty |

## Verification
The following results are due one clock edge after the accepted request, in the requesting domain:
- wr_check, full, almost_full and wr_overflow on the write side.
- The decoded word, both error flags, rd_check, empty, almost_empty and rd_underflow on the read side.

The bench drives on falling edges and samples on the next falling edge, which puts exactly one rising edge between stimulus and check. It moves traffic across domains only after a settling wait of several read-clock cycles, which covers the two-flop crossing. A scoreboard queue holds, for each write, the word, the expected stored check bits and the expected error outcome; each read pops one entry and compares against it.

// File: rtl/fifo_ecc_pkg.sv
package fifo_ecc_pkg;
  localparam int DATA_W  = 64;
  localparam int HAM_W   = 7;
  localparam int CHK_W   = HAM_W + 1;
  localparam int ENTRY_W = DATA_W + CHK_W;

  // Codeword position of data bit j: j-th non-power-of-two integer from 3 up
  function automatic logic [HAM_W-1:0] data_pos(input int j);
    logic [HAM_W-1:0] res;
    int n;
    res = '0;
    n = 0;
    for (int p = 1; p < (1 << HAM_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == j) res = HAM_W'(p);
        n++;
      end
    end
    return res;
  endfunction

  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = '0;
    for (int j = 0; j < DATA_W; j++) begin
      for (int i = 0; i < HAM_W; i++) begin
        if (data_pos(j)[i]) h[i] = h[i] ^ d[j];
      end
    end
    return h;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import fifo_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  logic [HAM_W-1:0] h;
  always_comb begin
    h   = ham_bits(data);
    chk = {^{data, h}, h};
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import fifo_ecc_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  output logic [DATA_W-1:0]  data,
  output logic               single,
  output logic               double
);
  logic [HAM_W-1:0] syn;
  logic             par_bad;

  always_comb begin
    syn     = ham_bits(entry[DATA_W-1:0]) ^ entry[DATA_W +: HAM_W];
    par_bad = ^entry;
    single  = par_bad;
    double  = !par_bad && (syn != '0);
  end

  for (genvar j = 0; j < DATA_W; j++) begin : g_fix
    localparam logic [HAM_W-1:0] POS = data_pos(j);
    assign data[j] = entry[j] ^ (par_bad && (syn == POS));
  end
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(s2 >> i);
  end
endmodule

// File: rtl/secded_async_fifo.sv
module secded_async_fifo
  import fifo_ecc_pkg::*;
#(
  parameter int DEPTH            = 16,
  parameter int ALMOST_FULL_LVL  = DEPTH - 4,
  parameter int ALMOST_EMPTY_LVL = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic               wr_clk,
  input  logic               rd_clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ENTRY_W-1:0] wr_inject,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  output logic [CHK_W-1:0]   rd_check,
  output logic               err_single,
  output logic               err_double,
  output logic [CHK_W-1:0]   wr_check,
  output logic               full,
  output logic               almost_full,
  output logic               empty,
  output logic               almost_empty,
  output logic [PW-1:0]      wr_count,
  output logic [PW-1:0]      rd_count,
  output logic               wr_overflow,
  output logic               rd_underflow
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] AF_P    = PW'(ALMOST_FULL_LVL);
  localparam logic [PW-1:0] AE_P    = PW'(ALMOST_EMPTY_LVL);

  logic [ENTRY_W-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0]    wbin, wnext, wgray, rbin_w, wfill;
  logic [CHK_W-1:0] enc_chk;
  logic             wacc;

  secded_enc u_enc (.data(wr_data), .chk(enc_chk));

  assign wacc  = wr_en && !full;
  assign wnext = wbin + 1'b1;
  assign wfill = wbin - rbin_w;
  assign full        = (wfill == DEPTH_P);
  assign almost_full = (wfill >= AF_P);
  assign wr_count    = wbin;

  always_ff @(posedge wr_clk or posedge rst) begin
    if (rst) begin
      wbin        <= '0;
      wgray       <= '0;
      wr_overflow <= 1'b0;
    end else begin
      wr_overflow <= wr_en && full;
      if (wacc) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wacc) begin
      mem[wbin[AW-1:0]] <= {enc_chk, wr_data} ^ wr_inject;
      wr_check          <= enc_chk;
    end
  end

  // read domain
  logic [PW-1:0]      rbin, rnext, rgray, wbin_r, rfill;
  logic [ENTRY_W-1:0] rword;
  logic               racc;

  assign racc  = rd_en && !empty;
  assign rnext = rbin + 1'b1;
  assign rfill = wbin_r - rbin;
  assign empty        = (rfill == '0);
  assign almost_empty = (rfill <= AE_P);
  assign rd_count     = rbin;

  always_ff @(posedge rd_clk or posedge rst) begin
    if (rst) begin
      rbin         <= '0;
      rgray        <= '0;
      rd_underflow <= 1'b0;
    end else begin
      rd_underflow <= rd_en && empty;
      if (racc) begin
        rbin  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end
    end
  end

  always_ff @(posedge rd_clk) begin
    if (racc) rword <= mem[rbin[AW-1:0]];
  end

  secded_dec u_dec (.entry(rword), .data(rd_data), .single(err_single), .double(err_double));
  assign rd_check = rword[DATA_W +: CHK_W];

  gray_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst(rst), .gray_in(rgray), .bin_out(rbin_w));
  gray_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst(rst), .gray_in(wgray), .bin_out(wbin_r));

  // R8
  wr_hold_chk: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_en && full) |=> $stable(wbin));
  // R9
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_en && empty) |=> ($stable(rbin) && $stable(rd_data)));
  // R10
  wfill_bound_chk: assert property (@(posedge wr_clk) disable iff (rst)
    wfill <= DEPTH_P);
  // R11
  rfill_bound_chk: assert property (@(posedge rd_clk) disable iff (rst)
    rfill <= DEPTH_P);
  // R2
  gray_step_chk: assert property (@(posedge wr_clk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray)));
  // R6
  one_outcome_chk: assert property (@(posedge rd_clk) disable iff (rst)
    !(err_single && err_double));
endmodule

// File: tb/tb_secded_async_fifo.sv
module tb_secded_async_fifo;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH = 16;

  logic        wr_clk = 0, rd_clk = 0, rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [63:0] wr_data = '0;
  logic [71:0] wr_inject = '0;
  logic [63:0] rd_data;
  logic [7:0]  rd_check, wr_check;
  logic        err_single, err_double, full, almost_full, empty, almost_empty;
  logic [4:0]  wr_count, rd_count;
  logic        wr_overflow, rd_underflow;

  secded_async_fifo #(.DEPTH(DEPTH)) dut (.*);

  always #(CLK_PERIOD/2)  wr_clk = ~wr_clk;
  always #(RCLK_PERIOD/2) rd_clk = ~rd_clk;

  typedef struct { logic [63:0] d; logic [7:0] c; bit sb; bit db; } exp_t;
  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def0;
  bit   done = 0;

  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [6:0] h;
    int k;
    h = '0;
    k = 0;
    for (int pos = 1; pos < 72; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int b = 0; b < 7; b++) if (pos[b]) h[b] = h[b] ^ d[k];
        k++;
      end
    end
    return {^{d, h}, h};
  endfunction

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] next_word();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed;
  endfunction

  // driver: write one word, push expectation
  task automatic push_word(input logic [63:0] d, input logic [71:0] inj, input bit sb, input bit db);
    exp_t e;
    @(negedge wr_clk);
    wr_en = 1; wr_data = d; wr_inject = inj;
    @(negedge wr_clk);
    wr_en = 0; wr_inject = '0;
    chk("R3 wr_check", 72'(wr_check), 72'(ref_chk(d)));
    e.d = d; e.c = ref_chk(d) ^ inj[71:64]; e.sb = sb; e.db = db;
    q.push_back(e);
  endtask

  // monitor: read one entry, pop and compare
  task automatic pop_word();
    exp_t e;
    @(negedge rd_clk);
    chk("R11 not empty before read", 72'(empty), 72'(0));
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    e = q.pop_front();
    if (!e.db) chk("R2/R4/R5 rd_data", 72'(rd_data), 72'(e.d));
    chk("R7 rd_check", 72'(rd_check), 72'(e.c));
    chk("R4/R5 err_single", 72'(err_single), 72'(e.sb));
    chk("R6 err_double", 72'(err_double), 72'(e.db));
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] hold_d;
    logic [7:0]  hold_c;
    logic [4:0]  hold_cnt;
    repeat (5) @(negedge rd_clk);
    // R1 during reset
    chk("R1 empty", 72'(empty), 72'(1));
    chk("R1 almost_empty", 72'(almost_empty), 72'(1));
    chk("R1 full", 72'(full), 72'(0));
    chk("R1 almost_full", 72'(almost_full), 72'(0));
    chk("R1 counts", 72'({wr_count, rd_count}), 72'(0));
    rst = 0;
    repeat (3) @(negedge rd_clk);
    chk("R1 empty after release", 72'(empty), 72'(1));

    // error patterns
    push_word(next_word(), 72'd0, 0, 0);
    push_word(next_word(), 72'd1 << 5, 1, 0);        // R4 data bit 5
    push_word(next_word(), 72'd1 << 63, 1, 0);       // R4 data bit 63
    push_word(next_word(), 72'd1 << 66, 1, 0);       // R5 check bit 2
    push_word(next_word(), 72'd1 << 71, 1, 0);       // R5 overall parity
    push_word(next_word(), (72'd1 << 3) | (72'd1 << 40), 0, 1); // R6
    push_word(next_word(), (72'd1 << 10) | (72'd1 << 68), 0, 1); // R6
    push_word(next_word(), 72'd0, 0, 0);
    repeat (6) @(negedge rd_clk);
    chk("R11 almost_empty at fill 8", 72'(almost_empty), 72'(0));
    chk("R10 almost_full at fill 8", 72'(almost_full), 72'(0));
    while (q.size() > 0) pop_word();
    repeat (6) @(negedge rd_clk);
    chk("R11 empty after drain", 72'(empty), 72'(1));

    // R9 underflow
    hold_d = rd_data; hold_c = rd_check; hold_cnt = rd_count;
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    chk("R9 rd_underflow", 72'(rd_underflow), 72'(1));
    chk("R9 rd_count", 72'(rd_count), 72'(hold_cnt));
    chk("R9 rd_data", 72'({rd_check, rd_data}), 72'({hold_c, hold_d}));
    @(negedge rd_clk);
    chk("R9 rd_underflow pulse", 72'(rd_underflow), 72'(0));

    // fill to full
    repeat (4) @(negedge wr_clk);
    for (int i = 1; i <= DEPTH; i++) begin
      push_word(next_word(), 72'd0, 0, 0);
      chk("R10 almost_full", 72'(almost_full), 72'(i >= DEPTH - 4));
      chk("R10 full", 72'(full), 72'(i == DEPTH));
    end
    hold_cnt = wr_count;
    @(negedge wr_clk); wr_en = 1; wr_data = 64'hdead_beef_dead_beef;
    @(negedge wr_clk); wr_en = 0;
    chk("R8 wr_overflow", 72'(wr_overflow), 72'(1));
    chk("R8 wr_count", 72'(wr_count), 72'(hold_cnt));
    @(negedge wr_clk);
    chk("R8 wr_overflow pulse", 72'(wr_overflow), 72'(0));
    chk("R8 wr_count value", 72'(wr_count), 72'(24 % 32));

    repeat (6) @(negedge rd_clk);
    for (int left = DEPTH - 1; left >= 0; left--) begin
      pop_word();
      chk("R11 almost_empty", 72'(almost_empty), 72'(left <= 4));
      chk("R11 empty", 72'(empty), 72'(left == 0));
    end

    // R12 reset keeps read outputs and wr_check
    hold_d = rd_data; hold_c = rd_check;
    begin
      logic [7:0] hold_w;
      logic [1:0] hold_f;
      hold_w = wr_check;
      hold_f = {err_single, err_double};
      @(negedge rd_clk); rst = 1;
      repeat (4) @(negedge rd_clk);
      chk("R12 rd_data kept", 72'({rd_check, rd_data}), 72'({hold_c, hold_d}));
      chk("R12 flags kept", 72'({err_single, err_double}), 72'(hold_f));
      chk("R12 wr_check kept", 72'(wr_check), 72'(hold_w));
      chk("R1 counts cleared", 72'({wr_count, rd_count}), 72'(0));
      rst = 0;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule